// File: doc/BRIEF.md
# Parallel FPGA Configuration Sequencer

This block loads a bitstream into one of two downstream programmable devices over a byte-wide parallel configuration port. A start command picks a target, a byte count and whether the target's enable pin is used. If the target is marked as fitted, the sequencer switches on its enable, lets go of its open-drain initialise line, and pulls its program line low for a set number of clocks. It then waits for the device to raise its initialise line, which means the device has cleared its configuration memory. Next it moves the requested number of bytes from a valid/ready byte stream onto that target's data bus, one write strobe per byte. Finally it waits for the device's completion line.

Two timeouts bound the run: one for the initialise wait and a longer one for the completion wait. The run ends with a one-cycle result pulse that carries a 2-bit code. The enable pin is low again by the time the code is posted, whatever the outcome. While a run is in progress, further start commands are ignored. Both status inputs pass through two-flop synchronisers before the sequencer uses them.

Top module: `pcfg_sequencer`

## Requirements
- R1: After reset: busy_o, done_valid_o, s_ready_o, enable_o and cfg_wr_o are all 0, prog_n_o is all ones, and init_low_o is all ones, so both initialise lines are held low.
- R2: A start that selects a target whose present_i bit is 0 posts result code 1 and touches none of that target's pins: no program pulse, enable stays low, and the initialise line stays as it was.
- R3: A start for a fitted target releases its initialise line (init_low_o bit goes to 0 and stays 0) and drives prog_n_o low for exactly PROG_CLKS cycles. Its enable_o is high during the run only when its en_use_i bit was 1 at start.
- R4: If the synchronised initialise input is still low PROG_CLKS+INIT_TO... more precisely, INIT_TO cycles after the program line returns high, the result is code 2 and no byte is accepted.
- R5: Once initialise is seen high, exactly length_i bytes are accepted on the valid/ready stream, in order. s_ready_o is high only during the data phase. Each accepted byte appears on cfg_data_o with a one-cycle cfg_wr_o pulse for the selected target in the cycle after it was accepted.
- R6: If the completion input does not go high within DONE_TO cycles after the data phase ends, the result is code 3.
- R7: If the completion input goes high in time, the result is code 0. A length of 0 skips the data phase.
- R8: enable_o is 0 in the cycle where done_valid_o is high, on every exit path.
- R9: Target 0 is the main target and target 1 is the mezzanine target, chosen by target_sel_i. The unselected target sees no program pulse, no enable and no write strobe.
- R10: start_i is ignored while busy_o is high. Each run yields exactly one done_valid_o pulse.
- R11: busy_o is high from the cycle after an accepted start up to and including the single-cycle done_valid_o pulse, and is low the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled while idle |
| target_sel_i | input | 1 | Target choice: 0 main, 1 mezzanine |
| present_i | input | 2 | Per-target fitted flag |
| en_use_i | input | 2 | Per-target use of the enable pin |
| length_i | input | LEN_W | Number of configuration bytes |
| busy_o | output | 1 | Run in progress |
| done_valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 2 | 0 ok, 1 absent, 2 no initialise, 3 no completion |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | DW | Byte stream data |
| s_ready_o | output | 1 | Byte stream ready |
| prog_n_o | output | 2 | Per-target program line, active low |
| init_low_o | output | 2 | Per-target open-drain pull-down of the initialise line |
| init_i | input | 2 | Per-target initialise line level |
| done_i | input | 2 | Per-target completion line level |
| enable_o | output | 2 | Per-target enable |
| cfg_wr_o | output | 2 | Per-target configuration write strobe |
| cfg_data_o | output | DW | Configuration data bus |

## Verification
Runs are tried on both targets with fitted and absent flags, and with the enable pin used and unused. Lengths of zero, a few bytes and ten bytes are used. Some runs keep the byte stream always valid and others gap it every third cycle, which separates correct throttling from a sequencer that writes on every cycle. Separate runs have initialise never rise, have completion never rise, or have both rise, so each of the four result codes and the exact timeout windows are told apart. A start raised again partway through a run shows whether it leaks onto the other target or produces a second result.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WINIT = 3'd2,
    ST_DATA  = 3'd3,
    ST_WDONE = 3'd4,
    ST_POST  = 3'd5
  } seq_state_e;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_ABSENT = 2'd1;
  localparam logic [1:0] RES_NOINIT = 2'd2;
  localparam logic [1:0] RES_NODONE = 2'd3;
endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)    cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pcfg_target_port.sv
module pcfg_target_port (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic in_job_i,
  input  logic prog_i,
  input  logic en_i,
  input  logic wr_i,
  output logic prog_n_o,
  output logic init_low_o,
  output logic enable_o,
  output logic wr_o
);
  logic hold_q;
  logic own_job;

  assign own_job = active_i & in_job_i;

  // Initialise line is held low from reset until this target's first run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b1;
    else if (own_job) hold_q <= 1'b0;
  end

  assign init_low_o = hold_q & ~own_job;
  assign prog_n_o   = ~(active_i & prog_i);
  assign enable_o   = own_job & en_i;
  assign wr_o       = active_i & wr_i;
endmodule

// File: rtl/pcfg_sequencer.sv
module pcfg_sequencer
  import pcfg_pkg::*;
#(
  parameter int PROG_CLKS = 20,
  parameter int INIT_TO   = 10000,
  parameter int DONE_TO   = 100000,
  parameter int LEN_W     = 16,
  parameter int DW        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             target_sel_i,
  input  logic [1:0]       present_i,
  input  logic [1:0]       en_use_i,
  input  logic [LEN_W-1:0] length_i,
  output logic             busy_o,
  output logic             done_valid_o,
  output logic [1:0]       result_o,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             s_ready_o,
  output logic [1:0]       prog_n_o,
  output logic [1:0]       init_low_o,
  input  logic [1:0]       init_i,
  input  logic [1:0]       done_i,
  output logic [1:0]       enable_o,
  output logic [1:0]       cfg_wr_o,
  output logic [DW-1:0]    cfg_data_o
);
  localparam int NT    = 2;
  localparam int MAXW  = (DONE_TO > INIT_TO) ? DONE_TO : INIT_TO;
  localparam int MAXT  = (MAXW > PROG_CLKS) ? MAXW : PROG_CLKS;
  localparam int TMR_W = $clog2(MAXT + 1);
  localparam logic [TMR_W-1:0] PROG_LAST = TMR_W'(PROG_CLKS - 1);
  localparam logic [TMR_W-1:0] INIT_LAST = TMR_W'(INIT_TO - 1);
  localparam logic [TMR_W-1:0] DONE_LAST = TMR_W'(DONE_TO - 1);

  seq_state_e       state_q, state_d;
  logic             sel_q;
  logic             en_q;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [1:0]       res_q, res_d;
  logic             wr_q;
  logic [DW-1:0]    data_q;
  logic [NT-1:0]    init_s, done_s;
  logic [TMR_W-1:0] tmr;
  logic             tmr_clr;
  logic             accept_start;
  logic             hs;
  logic             in_job;

  pcfg_sync #(.W(NT)) u_sync_init (.clk(clk), .rst_n(rst_n), .d_i(init_i), .q_o(init_s));
  pcfg_sync #(.W(NT)) u_sync_done (.clk(clk), .rst_n(rst_n), .d_i(done_i), .q_o(done_s));

  pcfg_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(tmr_clr), .inc_i(1'b1), .count_o(tmr)
  );

  assign accept_start = (state_q == ST_IDLE) & start_i;
  assign hs           = (state_q == ST_DATA) & s_valid_i;
  assign in_job       = (state_q == ST_PROG) | (state_q == ST_WINIT) |
                        (state_q == ST_DATA) | (state_q == ST_WDONE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    rem_d   = rem_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          rem_d = length_i;
          if (present_i[target_sel_i]) begin
            state_d = ST_PROG;
          end else begin
            state_d = ST_POST;
            res_d   = RES_ABSENT;
          end
        end
      end
      ST_PROG: begin
        if (tmr == PROG_LAST) state_d = ST_WINIT;
      end
      ST_WINIT: begin
        if (init_s[sel_q]) begin
          state_d = (rem_q == '0) ? ST_WDONE : ST_DATA;
        end else if (tmr == INIT_LAST) begin
          state_d = ST_POST;
          res_d   = RES_NOINIT;
        end
      end
      ST_DATA: begin
        if (hs) begin
          rem_d = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) state_d = ST_WDONE;
        end
      end
      ST_WDONE: begin
        if (done_s[sel_q]) begin
          state_d = ST_POST;
          res_d   = RES_OK;
        end else if (tmr == DONE_LAST) begin
          state_d = ST_POST;
          res_d   = RES_NODONE;
        end
      end
      ST_POST:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q) | (state_q == ST_IDLE);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= RES_OK;
      rem_q   <= '0;
      sel_q   <= 1'b0;
      en_q    <= 1'b0;
      wr_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      rem_q   <= rem_d;
      wr_q    <= hs;
      if (accept_start) begin
        sel_q <= target_sel_i;
        en_q  <= en_use_i[target_sel_i];
      end
      if (hs) data_q <= s_data_i;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_port
    pcfg_target_port u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (sel_q == t[0]),
      .in_job_i   (in_job),
      .prog_i     (state_q == ST_PROG),
      .en_i       (en_q),
      .wr_i       (wr_q),
      .prog_n_o   (prog_n_o[t]),
      .init_low_o (init_low_o[t]),
      .enable_o   (enable_o[t]),
      .wr_o       (cfg_wr_o[t])
    );
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_valid_o = (state_q == ST_POST);
  assign result_o     = res_q;
  assign s_ready_o    = (state_q == ST_DATA);
  assign cfg_data_o   = data_q;
endmodule

// File: rtl/pcfg_sequencer_chk.sv
module pcfg_sequencer_chk #(
  parameter int PROG_CLKS = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_valid_o,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic [1:0] prog_n_o,
  input logic [1:0] enable_o,
  input logic [1:0] cfg_wr_o
);
  localparam int CW = $clog2(PROG_CLKS + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (!(&prog_n_o)) begin
      if (low_cnt != CMAX)    low_cnt <= low_cnt + 1'b1;
    end else                  low_cnt <= '0;
  end

  assert_prog_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((&prog_n_o) && !$past(&prog_n_o)) |-> (low_cnt == CW'(PROG_CLKS)));

  assert_ready_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> busy_o);

  assert_wr_follows_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_wr_o) |-> $past(s_valid_i && s_ready_o));

  assert_enable_off_at_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_o |-> (enable_o == 2'b00));

  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~prog_n_o) && $onehot0(cfg_wr_o) && $onehot0(enable_o));

  assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_o |=> !done_valid_o);

  assert_busy_at_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_o |-> busy_o);
endmodule

bind pcfg_sequencer pcfg_sequencer_chk #(.PROG_CLKS(PROG_CLKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_valid_o (done_valid_o),
  .s_valid_i    (s_valid_i),
  .s_ready_o    (s_ready_o),
  .prog_n_o     (prog_n_o),
  .enable_o     (enable_o),
  .cfg_wr_o     (cfg_wr_o)
);

// File: tb/pcfg_sequencer_tb.sv
module pcfg_sequencer_tb_top;
  localparam int PROG_CLKS = 20;
  localparam int INIT_TO   = 40;
  localparam int DONE_TO   = 60;
  localparam int LEN_W     = 8;
  localparam int DW        = 8;
  localparam logic [7:0] NEVER = 8'hFF;

  typedef struct packed {
    logic       sel;
    logic [1:0] pres;
    logic [1:0] enu;
    logic [7:0] len;
    logic [7:0] idly;
    logic [7:0] ddly;
    logic       gap;
    logic [7:0] rs;
    logic [1:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b01, 2'b11, 8'd5,  8'd3,  8'd3,  1'b0, 8'd0, 2'd1},
    '{1'b0, 2'b01, 2'b01, 8'd8,  8'd5,  8'd4,  1'b0, 8'd0, 2'd0},
    '{1'b0, 2'b01, 2'b00, 8'd6,  NEVER, 8'd0,  1'b0, 8'd0, 2'd2},
    '{1'b0, 2'b11, 2'b11, 8'd7,  8'd2,  NEVER, 1'b1, 8'd0, 2'd3},
    '{1'b1, 2'b11, 2'b10, 8'd10, 8'd10, 8'd6,  1'b1, 8'd0, 2'd0},
    '{1'b1, 2'b11, 2'b00, 8'd0,  8'd4,  8'd3,  1'b0, 8'd0, 2'd0},
    '{1'b1, 2'b11, 2'b10, 8'd3,  NEVER, 8'd0,  1'b0, 8'd0, 2'd2},
    '{1'b0, 2'b10, 2'b11, 8'd4,  8'd1,  8'd1,  1'b0, 8'd0, 2'd1},
    '{1'b0, 2'b11, 2'b01, 8'd3,  8'd2,  8'd2,  1'b0, 8'd3, 2'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic             target_sel_i;
  logic [1:0]       present_i;
  logic [1:0]       en_use_i;
  logic [LEN_W-1:0] length_i;
  logic             busy_o, done_valid_o, s_ready_o, s_valid_i;
  logic [1:0]       result_o, prog_n_o, init_low_o, init_i, done_i, enable_o, cfg_wr_o;
  logic [DW-1:0]    s_data_i, cfg_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [1:0] released = 2'b00;

  always #4 clk = ~clk;

  pcfg_sequencer #(
    .PROG_CLKS(PROG_CLKS), .INIT_TO(INIT_TO), .DONE_TO(DONE_TO), .LEN_W(LEN_W), .DW(DW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_sel_i(target_sel_i),
    .present_i(present_i), .en_use_i(en_use_i), .length_i(length_i),
    .busy_o(busy_o), .done_valid_o(done_valid_o), .result_o(result_o),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .prog_n_o(prog_n_o), .init_low_o(init_low_o), .init_i(init_i), .done_i(done_i),
    .enable_o(enable_o), .cfg_wr_o(cfg_wr_o), .cfg_data_o(cfg_data_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'((v * 16) + (k * 5) + 8'h21);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_job(input int v);
    vec_t x = VECS[v];
    int o = x.sel ? 0 : 1;
    int low = 0, since = 0, wcnt = 0, k = 0, dcnt = 0, loops = 0;
    logic rose = 1'b0, igiven = 1'b0, hs_pend = 1'b0, en_seen = 1'b0, other_bad = 1'b0, data_bad = 1'b0;
    logic finished = 1'b0;
    target_sel_i = x.sel; present_i = x.pres; en_use_i = x.enu;
    length_i = x.len; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    while (!finished && loops < 2000) begin
      loops++;
      if (hs_pend) k++;
      if (x.rs != 0 && loops == int'(x.rs)) begin
        start_i = 1'b1; target_sel_i = ~x.sel; present_i = 2'b11; en_use_i = 2'b11;
        length_i = 8'd1;
      end else start_i = 1'b0;
      s_valid_i = x.gap ? ((loops % 3) != 0) : 1'b1;
      s_data_i  = pat(v, k);
      hs_pend   = s_ready_o && s_valid_i;
      if (!prog_n_o[x.sel]) low++;
      if (prog_n_o[o] !== 1'b1 || enable_o[o] !== 1'b0 || cfg_wr_o[o] !== 1'b0) other_bad = 1'b1;
      if (enable_o[x.sel]) en_seen = 1'b1;
      if (rose) since++;
      if (!rose && low > 0 && prog_n_o[x.sel]) begin rose = 1'b1; since = 0; end
      if (rose && x.idly != NEVER && since >= int'(x.idly)) begin
        init_i[x.sel] = 1'b1; igiven = 1'b1;
      end
      if (igiven && wcnt == int'(x.len)) dcnt++;
      if (x.ddly != NEVER && dcnt >= int'(x.ddly) && dcnt > 0) done_i[x.sel] = 1'b1;
      if (cfg_wr_o[x.sel]) begin
        if (cfg_data_o !== pat(v, wcnt)) data_bad = 1'b1;
        wcnt++;
      end
      if (done_valid_o) begin
        finished = 1'b1;
        chk(result_o == x.exp, $sformatf("R2/R4/R6/R7 result code vec %0d", v), result_o, x.exp);
        chk(enable_o == 2'b00, $sformatf("R8 enable low at result vec %0d", v), enable_o, 0);
        chk(busy_o == 1'b1, $sformatf("R11 busy during result vec %0d", v), busy_o, 1);
        chk(!other_bad, $sformatf("R9 other target untouched vec %0d", v), other_bad, 0);
        chk(!data_bad, $sformatf("R5 byte values in order vec %0d", v), data_bad, 0);
        chk(en_seen == (x.pres[x.sel] & x.enu[x.sel]),
            $sformatf("R3 enable use vec %0d", v), en_seen, x.pres[x.sel] & x.enu[x.sel]);
        if (x.exp == 2'd1) begin
          chk(low == 0, $sformatf("R2 no program pulse vec %0d", v), low, 0);
          chk(init_low_o[x.sel] == ~released[x.sel], $sformatf("R2 init line untouched vec %0d", v),
              init_low_o[x.sel], ~released[x.sel]);
        end else begin
          released[x.sel] = 1'b1;
          chk(low == PROG_CLKS, $sformatf("R3 program pulse width vec %0d", v), low, PROG_CLKS);
          chk(init_low_o[x.sel] == 1'b0, $sformatf("R3 init released vec %0d", v), init_low_o[x.sel], 0);
        end
        if (x.exp == 2'd2) begin
          chk(since == INIT_TO, $sformatf("R4 init timeout window vec %0d", v), since, INIT_TO);
          chk(wcnt == 0, $sformatf("R4 no bytes written vec %0d", v), wcnt, 0);
        end
        if (x.exp == 2'd0 || x.exp == 2'd3) begin
          chk(wcnt == int'(x.len), $sformatf("R5 byte count vec %0d", v), wcnt, x.len);
          chk(k == int'(x.len), $sformatf("R5 accepted count vec %0d", v), k, x.len);
        end
        if (x.exp == 2'd3)
          chk(dcnt == DONE_TO, $sformatf("R6 done timeout window vec %0d", v), dcnt, DONE_TO);
      end else begin
        @(posedge clk); @(negedge clk);
      end
    end
    chk(finished, $sformatf("R11 run finished vec %0d", v), finished, 1);
    start_i = 1'b0; s_valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(busy_o == 1'b0, $sformatf("R11 busy low after result vec %0d", v), busy_o, 0);
    init_i = 2'b00; done_i = 2'b00;
    for (int i = 0; i < 4; i++) begin
      chk(done_valid_o == 1'b0 && busy_o == 1'b0,
          $sformatf("R10 no second run or result vec %0d", v), done_valid_o, 0);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; target_sel_i = 1'b0; present_i = 2'b00;
    en_use_i = 2'b00; length_i = '0; s_valid_i = 1'b0; s_data_i = '0;
    init_i = 2'b00; done_i = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && done_valid_o == 0 && s_ready_o == 0, "R1 idle flags", busy_o, 0);
    chk(prog_n_o == 2'b11, "R1 program lines high", prog_n_o, 3);
    chk(init_low_o == 2'b11, "R1 init lines held low", init_low_o, 3);
    chk(enable_o == 2'b00 && cfg_wr_o == 2'b00, "R1 enable and strobes low", enable_o, 0);

    for (int v = 0; v < NV; v++) run_job(v);

    s_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_ready_o == 1'b0 && cfg_wr_o == 2'b00, "R5 no accept while idle", s_ready_o, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_low_o == 2'b11 && prog_n_o == 2'b11, "R1 state after second reset", init_low_o, 3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule